// File: doc/BRIEF.md
# Byte-Slot Frame Timing Generator with External Alignment

This block sets the byte-slot timing of a 155 Mb/s synchronous optical frame on a 19.44 MHz byte clock. A frame is 2430 byte slots long, laid out as 9 rows of 270 columns. The block counts these slots and drives three outputs: a column counter, a row counter, and a strobe that is high during byte 0 of every frame. With no alignment source, the count runs free and wraps every 2430 clocks, which gives an 8 kHz frame rate.

An external 8 kHz sync pulse can set the frame phase when alignment is enabled. The pulse is one byte-clock wide and is already synchronous to the byte clock. Only its rising edge counts. A programmable delay sets how many clocks after the detected edge frame byte 0 appears. If the realignment lands exactly where the free count would wrap anyway, the timing does not change. If the sync input is tied low, the block simply free-runs. The outputs are plain timing pins with no handshake, because no data passes through the block.

Top module: `frm_timing_gen`

## Requirements
- R1: On the first clock cycle after reset is released, row and column are both 0 and frame_start is 1.
- R2: Without a realignment, column rises by 1 each clock from 0 to 269 and then returns to 0. Each time column returns to 0, row rises by 1, and after row 8 it returns to 0. Row never exceeds 8 and column never exceeds 269.
- R3: With sync_in held low, frame_start is 1 in exactly one cycle out of every 2430, and that cycle is the one where row and column are both 0.
- R4: A rising edge is detected at a clock edge where sync_in is sampled 1 and was sampled 0 at the edge before. Holding sync_in high for several clocks gives only one realignment.
- R5: With sync_en = 1 and sync_dly = 0, a rising edge detected at clock edge k makes the cycle that follows edge k frame byte 0, with row 0, column 0 and frame_start 1.
- R6: With sync_dly = D > 0, frame byte 0 appears D clocks later than it would with zero delay, which means in the cycle after clock edge k+D. The count then runs on from there.
- R7: If the realigned byte 0 falls in the same cycle as the free count's own wrap to byte 0, the outputs are the same as with no sync at all.
- R8: While sync_en = 0, rising edges are ignored, and a realignment that is still waiting out its delay is cancelled.
- R9: A new rising edge that arrives while an earlier delay is still running discards the earlier one. The delay is then measured from the new edge, using the sync_dly value sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 19.44 MHz byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | External 8 kHz alignment pulse, synchronous to clk |
| sync_en | input | 1 | 1 = align to sync_in, 0 = free-run |
| sync_dly | input | DLY_W (12) | Clocks from detected edge to frame byte 0 |
| frame_start | output | 1 | High during frame byte 0 |
| row | output | ROW_W (4) | Current row, 0 to ROWS-1 |
| col | output | COL_W (9) | Current column, 0 to COLS-1 |

## Verification
Two cases are provoked on purpose. The first is a realignment reload that falls in the same cycle as the counter's natural wrap from byte 2429 to byte 0. The bench places the sync edge exactly the programmed delay ahead of that wrap and requires the row and column sequence to run on without a break. The second is a fresh sync edge that arrives in the same cycle as an earlier delay expires, or while that delay is still running. In that case the bench requires the earlier reload to be dropped, so byte 0 appears only at the point set by the newer edge and its delay. Both cases are judged cycle by cycle against a position model computed in the bench.

// File: rtl/frm_timing_pkg.sv
package frm_timing_pkg;
  typedef enum logic [0:0] {
    ALIGN_IDLE  = 1'b0,
    ALIGN_WAIT  = 1'b1
  } align_state_e;

  function automatic int unsigned width_of(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic rise
);
  logic sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_in;
  end

  assign rise = sync_in & ~sync_q;
endmodule

// File: rtl/realign_delay.sv
module realign_delay
  import frm_timing_pkg::*;
#(
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             sync_en,
  input  logic [DLY_W-1:0] dly,
  output logic             reload
);
  align_state_e     state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    reload  = 1'b0;
    if (!sync_en) begin
      state_d = ALIGN_IDLE;
    end else if (rise) begin
      if (dly == '0) begin
        reload  = 1'b1;
        state_d = ALIGN_IDLE;
      end else begin
        state_d = ALIGN_WAIT;
        cnt_d   = dly - DLY_W'(1);
      end
    end else if (state_q == ALIGN_WAIT) begin
      if (cnt_q == '0) begin
        reload  = 1'b1;
        state_d = ALIGN_IDLE;
      end else begin
        cnt_d = cnt_q - DLY_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ALIGN_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/frame_pos_ctr.sv
module frame_pos_ctr #(
  parameter int ROWS  = 9,
  parameter int COLS  = 270,
  parameter int ROW_W = 4,
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic col_wrap;
  assign col_wrap = (col == COL_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
    end else if (reload || col_wrap) begin
      col <= '0;
    end else begin
      col <= col + COL_W'(1);
    end
  end

  generate
    if (ROWS > 1) begin : g_rows
      always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
          row <= '0;
        end else if (col_wrap) begin
          row <= (row == ROW_LAST) ? '0 : row + ROW_W'(1);
        end
      end
    end else begin : g_single_row
      always_ff @(posedge clk) begin
        row <= '0;
      end
    end
  endgenerate
endmodule

// File: rtl/frm_timing_gen.sv
module frm_timing_gen
  import frm_timing_pkg::*;
#(
  parameter int ROWS  = 9,
  parameter int COLS  = 270,
  parameter int DLY_W = 12,
  parameter int ROW_W = width_of(ROWS),
  parameter int COL_W = width_of(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             sync_en,
  input  logic [DLY_W-1:0] sync_dly,
  output logic             frame_start,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);
  logic sync_rise;
  logic reload;

  sync_edge_det i_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_in (sync_in),
    .rise    (sync_rise)
  );

  realign_delay #(.DLY_W(DLY_W)) i_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (sync_rise),
    .sync_en (sync_en),
    .dly     (sync_dly),
    .reload  (reload)
  );

  frame_pos_ctr #(
    .ROWS  (ROWS),
    .COLS  (COLS),
    .ROW_W (ROW_W),
    .COL_W (COL_W)
  ) i_pos (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (reload),
    .row    (row),
    .col    (col)
  );

  assign frame_start = (row == '0) && (col == '0);
endmodule

// File: rtl/frm_timing_chk.sv
module frm_timing_chk #(
  parameter int ROWS  = 9,
  parameter int COLS  = 270,
  parameter int DLY_W = 12,
  parameter int ROW_W = 4,
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_en,
  input logic [DLY_W-1:0] sync_dly,
  input logic             rise,
  input logic             reload,
  input logic             frame_start,
  input logic [ROW_W-1:0] row,
  input logic [COL_W-1:0] col
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (col <= COL_LAST) && (row <= ROW_LAST));

  a_r2_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && col != COL_LAST) |=> (col == $past(col) + COL_W'(1)));

  a_r2_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && col == COL_LAST && row != ROW_LAST) |=>
      (col == '0 && row == $past(row) + ROW_W'(1)));

  a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && col == COL_LAST && row == ROW_LAST) |=> frame_start);

  a_r5_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && sync_en && sync_dly == '0) |-> reload);

  a_r6_reload_byte0: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (frame_start && row == '0 && col == '0));

  a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |-> !reload);
endmodule

bind frm_timing_gen frm_timing_chk #(
  .ROWS  (ROWS),
  .COLS  (COLS),
  .DLY_W (DLY_W),
  .ROW_W (ROW_W),
  .COL_W (COL_W)
) i_frm_timing_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_en     (sync_en),
  .sync_dly    (sync_dly),
  .rise        (sync_rise),
  .reload      (reload),
  .frame_start (frame_start),
  .row         (row),
  .col         (col)
);

// File: tb/test_frm_timing_gen.sv
`timescale 1ns/1ps
module test_frm_timing_gen;
  localparam int ROWS  = 9;
  localparam int COLS  = 270;
  localparam int DLY_W = 12;
  localparam int FRAME = ROWS * COLS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sync_in = 1'b0;
  logic             sync_en = 1'b0;
  logic [DLY_W-1:0] sync_dly = '0;
  logic             frame_start;
  logic [3:0]       row;
  logic [8:0]       col;

  int checks = 0;
  int errors = 0;
  int m_pos = 0;
  bit m_q = 1'b0;
  bit m_pend = 1'b0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  frm_timing_gen i_frm_timing_gen (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_en(sync_en),
    .sync_dly(sync_dly), .frame_start(frame_start), .row(row), .col(col)
  );

  function automatic int next_pos(input int p);
    return (p == FRAME - 1) ? 0 : p + 1;
  endfunction

  task automatic check_out(input string tag);
    int er, ec;
    bit ef;
    er = m_pos / COLS;
    ec = m_pos % COLS;
    ef = (m_pos == 0);
    checks++;
    if (int'(row) != er || int'(col) != ec || frame_start != ef) begin
      errors++;
      $display("FAIL %s: row=%0d col=%0d fs=%0b expected row=%0d col=%0d fs=%0b",
               tag, row, col, frame_start, er, ec, ef);
    end
  endtask

  task automatic model_edge(input bit s, input bit en, input int d);
    bit rise, rld;
    rise = s && !m_q;
    m_q = s;
    rld = 1'b0;
    if (!en) begin
      m_pend = 1'b0;
    end else if (rise) begin
      if (d == 0) begin rld = 1'b1; m_pend = 1'b0; end
      else begin m_pend = 1'b1; m_cnt = d - 1; end
    end else if (m_pend) begin
      if (m_cnt == 0) begin rld = 1'b1; m_pend = 1'b0; end
      else m_cnt = m_cnt - 1;
    end
    m_pos = rld ? 0 : next_pos(m_pos);
  endtask

  task automatic step(input bit s, input bit en, input int d, input string tag);
    sync_in = s;
    sync_en = en;
    sync_dly = DLY_W'(d);
    @(posedge clk);
    model_edge(s, en, d);
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic idle(input int n, input int d, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, d, tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected end before timeout");
    finish_run();
  end

  initial begin
    int fs_count;
    void'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check_out("R1 reset state");

    // R2 R3: free running over more than a frame, sync tied low
    fs_count = 0;
    for (int i = 0; i < FRAME + 20; i++) begin
      step(1'b0, 1'b1, 0, "R2 R3 free run");
      if (frame_start) fs_count++;
    end
    checks++;
    if (fs_count != 1) begin
      errors++;
      $display("FAIL R3 frame_start count: actual %0d expected 1", fs_count);
    end

    // R5: zero delay
    idle(37, 0, "R5 lead-in");
    step(1'b1, 1'b1, 0, "R5 zero delay edge");
    idle(30, 0, "R5 after edge");

    // R6: programmed delay
    idle(101, 7, "R6 lead-in");
    step(1'b1, 1'b1, 7, "R6 delayed edge");
    idle(40, 7, "R6 after edge");

    // R4: held-high sync gives one realignment only
    idle(55, 3, "R4 lead-in");
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 3, "R4 level held");
    idle(FRAME + 5, 3, "R4 after level");

    // R7: realignment coinciding with natural wrap
    while (m_pos != FRAME - 1 - 4) step(1'b0, 1'b1, 4, "R7 approach");
    step(1'b1, 1'b1, 4, "R7 aligned edge");
    idle(40, 4, "R7 continuity");

    // R8: disabled alignment ignores edges and cancels pending
    idle(13, 0, "R8 lead-in");
    step(1'b1, 1'b0, 0, "R8 edge while disabled");
    idle(20, 0, "R8 after ignored edge");
    step(1'b1, 1'b1, 10, "R8 arm delay");
    idle(3, 10, "R8 waiting");
    step(1'b0, 1'b0, 10, "R8 cancel");
    idle(30, 10, "R8 after cancel");

    // R9: new edge during pending delay restarts it
    idle(17, 20, "R9 lead-in");
    step(1'b1, 1'b1, 20, "R9 first edge");
    idle(5, 20, "R9 waiting");
    step(1'b1, 1'b1, 20, "R9 second edge");
    idle(50, 20, "R9 after restart");
    // R9: second edge on the exact cycle the first delay expires
    step(1'b1, 1'b1, 2, "R9 first edge short");
    step(1'b0, 1'b1, 2, "R9 gap");
    step(1'b1, 1'b1, 9, "R9 edge at expiry");
    idle(30, 9, "R9 after collision");

    // Random mix
    for (int i = 0; i < 30000; i++) begin
      bit s, en;
      int d;
      s  = ($urandom % 150) == 0;
      en = ($urandom % 25) != 0;
      d  = ($urandom % 4 == 0) ? 0 : int'($urandom % 80);
      step(s, en, d, "R2 R9 random");
    end

    finish_run();
  end
endmodule